// File: doc/BRIEF.md
# Configuration Memory Scrubbing Controller

This controller keeps a device's configuration memory free of accumulated bit flips while the user logic keeps running. A periodic tick starts a pass. In a pass the controller goes through every frame address in order. For each frame it reads the live words back through a simple frame read/write port, fetches the matching golden words from an external non-volatile memory, and compares them word by word. If any word in the frame differs, the controller writes the whole golden frame back into the configuration memory. It then moves on to the next frame.

The golden memory is shared with a host processor. The host always wins: its request is granted in the same cycle. The scrubber reads a golden word only in a cycle where the host is not asking, and it gives the memory up again after every word. No separate configuration manager is needed.

Telemetry is a saturating count of corrected frames, a pulse at the end of each full pass, and a port-failure flag. The flag is raised when a readback never completes, and that pass is then aborted.

Top module: `cfg_scrubber`

## Requirements
- R1: A one-cycle `scrub_tick` while `busy` is low starts a pass, and `busy` stays high until the pass ends. A tick that arrives while a pass is running is ignored: it causes no second pass and no second `pass_done`.
- R2: For each frame the controller reads every word, index 0 to WORDS-1, through the configuration port. Each read is a single-cycle `cfg_rd_req` with `cfg_frame`/`cfg_word` set, and the read completes when `cfg_rd_ack` is high with `cfg_rd_data`. Acknowledge latency may be any number of cycles below the timeout.
- R3: `host_gnt` equals `host_req` in the same cycle. `gm_rd_en` is never high in a cycle where `host_req` is high, and it is never high in two consecutive cycles. Golden data is taken from `gm_rd_data` one cycle after `gm_rd_en`, and the address is `frame*WORDS + word`.
- R4: A frame that has at least one word differing from its golden copy is rewritten in full: WORDS write cycles (`cfg_wr_en`), words 0 to WORDS-1, carrying the golden data. A frame whose words all match gets no write.
- R5: After a pass that completes, every configuration word equals its golden word.
- R6: `fix_count` goes up by exactly one for every rewritten frame and holds at 2^CNT_W-1 once it reaches that value.
- R7: `pass_done` is a one-cycle pulse that follows the last frame of a pass that completed.
- R8: If a readback gets no acknowledge within TIMEOUT cycles, `port_fail` is set, the pass is aborted with no `pass_done`, and `busy` falls. `port_fail` is cleared when the next pass starts.
- R9: After the synchronous active-high reset, `busy`, `pass_done`, `port_fail`, `fix_count`, `cfg_rd_req`, `cfg_wr_en` and `gm_rd_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scrub_tick | input | 1 | Pass start request (scrub period tick) |
| cfg_rd_req | output | 1 | Single-cycle readback request |
| cfg_wr_en | output | 1 | Configuration word write strobe |
| cfg_frame | output | FR_W | Frame address of current access |
| cfg_word | output | WIDX_W | Word index within the frame |
| cfg_wr_data | output | DATA_W | Golden word being written back |
| cfg_rd_ack | input | 1 | Readback word valid |
| cfg_rd_data | input | DATA_W | Readback word |
| gm_rd_en | output | 1 | Golden memory read strobe (scrubber holds grant) |
| gm_addr | output | GM_AW | Golden word address |
| gm_rd_data | input | DATA_W | Golden word, valid the cycle after gm_rd_en |
| host_req | input | 1 | Host request for the golden memory |
| host_gnt | output | 1 | Grant to the host |
| busy | output | 1 | Pass in progress |
| pass_done | output | 1 | Pulse at the end of a completed pass |
| port_fail | output | 1 | Readback timeout seen in last pass |
| fix_count | output | CNT_W | Saturating count of corrected frames |

## Verification
The mismatch flag, the frame buffer and the word index are internal state. When one of them is wrong, the result shows up at the ports before the pass ends: a corrupted frame is not repaired, a clean frame is written, or the number of write strobes in a pass does not match the frames that differ. A wrong frame counter or a wrong exit from the state machine changes `fix_count` or the timing of `pass_done` by the end of the same pass. An arbitration fault shows as `gm_rd_en` in the same cycle as `host_req`, so it is caught in that cycle.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_LIVE,
        S_READ_GOLD,
        S_COMPARE,
        S_REWRITE,
        S_NEXT_FRAME
    } scrub_state_t;

    typedef struct packed {
        logic rd_pend;
        logic gm_pend;
        logic dirty;
    } scrub_flags_t;

    function automatic logic [31:0] sat_step(input logic [31:0] cur, input logic [31:0] lim);
        return (cur >= lim) ? lim : cur + 32'd1;
    endfunction

endpackage

// File: rtl/scrub_arb.sv
module scrub_arb (
    input  logic host_req,
    input  logic scrub_want,
    output logic host_gnt,
    output logic scrub_gnt
);
    always_comb begin
        host_gnt  = host_req;
        scrub_gnt = scrub_want && !host_req;
    end
endmodule

// File: rtl/scrub_frame_buf.sv
module scrub_frame_buf #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == WIDX_W'(w)))
                slot_q[w] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
    import scrub_pkg::*;
#(
    parameter int FRAMES  = 8,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 16,
    parameter int CNT_W   = 4,
    localparam int FR_W   = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int TMR_W  = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scrub_tick,
    input  logic              cfg_rd_ack,
    input  logic              scrub_gnt,
    input  logic [DATA_W-1:0] gm_rd_data,
    input  logic [DATA_W-1:0] buf_rd_data,
    output logic              cfg_rd_req,
    output logic              cfg_wr_en,
    output logic              scrub_want,
    output logic              buf_wr_en,
    output logic              buf_sel_gold,
    output logic [FR_W-1:0]   frame,
    output logic [WIDX_W-1:0] word,
    output logic              busy,
    output logic              pass_done,
    output logic              port_fail,
    output logic [CNT_W-1:0]  fix_count
);
    localparam logic [FR_W-1:0]   LAST_F  = FR_W'(FRAMES - 1);
    localparam logic [WIDX_W-1:0] LAST_W  = WIDX_W'(WORDS - 1);
    localparam logic [TMR_W-1:0]  TMR_END = TMR_W'(TIMEOUT - 1);
    localparam logic [31:0]       CNT_MAX = 32'((64'd1 << CNT_W) - 1);

    scrub_state_t      state_q;
    scrub_flags_t      fl_q;
    logic [TMR_W-1:0]  timer_q;
    logic              mismatch;

    assign mismatch     = (gm_rd_data != buf_rd_data);
    assign cfg_rd_req   = (state_q == S_READ_LIVE) && !fl_q.rd_pend;
    assign scrub_want   = (state_q == S_READ_GOLD) && !fl_q.gm_pend;
    assign cfg_wr_en    = (state_q == S_REWRITE);
    assign buf_sel_gold = (state_q == S_READ_GOLD);
    assign buf_wr_en    = ((state_q == S_READ_LIVE) && fl_q.rd_pend && cfg_rd_ack) ||
                          ((state_q == S_READ_GOLD) && fl_q.gm_pend);
    assign busy         = (state_q != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            fl_q      <= '0;
            timer_q   <= '0;
            frame     <= '0;
            word      <= '0;
            pass_done <= 1'b0;
            port_fail <= 1'b0;
            fix_count <= '0;
        end else begin
            pass_done <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (scrub_tick) begin
                        port_fail <= 1'b0;
                        frame     <= '0;
                        word      <= '0;
                        fl_q      <= '0;
                        state_q   <= S_READ_LIVE;
                    end
                end
                S_READ_LIVE: begin
                    if (!fl_q.rd_pend) begin
                        fl_q.rd_pend <= 1'b1;
                        timer_q      <= '0;
                    end else if (cfg_rd_ack) begin
                        fl_q.rd_pend <= 1'b0;
                        if (word == LAST_W) begin
                            word    <= '0;
                            state_q <= S_READ_GOLD;
                        end else begin
                            word <= word + 1'b1;
                        end
                    end else if (timer_q == TMR_END) begin
                        fl_q.rd_pend <= 1'b0;
                        port_fail    <= 1'b1;
                        state_q      <= S_IDLE;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                S_READ_GOLD: begin
                    if (fl_q.gm_pend) begin
                        fl_q.gm_pend <= 1'b0;
                        if (mismatch)
                            fl_q.dirty <= 1'b1;
                        if (word == LAST_W) begin
                            word    <= '0;
                            state_q <= S_COMPARE;
                        end else begin
                            word <= word + 1'b1;
                        end
                    end else if (scrub_gnt) begin
                        fl_q.gm_pend <= 1'b1;
                    end
                end
                S_COMPARE: begin
                    state_q <= fl_q.dirty ? S_REWRITE : S_NEXT_FRAME;
                end
                S_REWRITE: begin
                    if (word == LAST_W) begin
                        word    <= '0;
                        state_q <= S_NEXT_FRAME;
                    end else begin
                        word <= word + 1'b1;
                    end
                end
                S_NEXT_FRAME: begin
                    if (fl_q.dirty)
                        fix_count <= CNT_W'(sat_step(32'(fix_count), CNT_MAX));
                    fl_q.dirty <= 1'b0;
                    if (frame == LAST_F) begin
                        pass_done <= 1'b1;
                        state_q   <= S_IDLE;
                    end else begin
                        frame   <= frame + 1'b1;
                        state_q <= S_READ_LIVE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R2
    rd_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_req |=> !cfg_rd_req);
    // R3
    gm_one_word_chk: assert property (@(posedge clk) disable iff (rst)
        scrub_gnt |=> !scrub_gnt);
    // R4
    wr_only_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> fl_q.dirty);
    // R6
    fix_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fix_count != $past(fix_count)) |-> (fix_count == $past(fix_count) + 1'b1));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pass_done |=> !pass_done);
    // R8
    fail_abort_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(port_fail) |-> (!busy && !pass_done));
endmodule

// File: rtl/cfg_scrubber.sv
module cfg_scrubber #(
    parameter int FRAMES  = 8,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 16,
    parameter int CNT_W   = 4,
    localparam int FR_W   = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int GM_AW  = ((FRAMES * WORDS) > 1) ? $clog2(FRAMES * WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scrub_tick,
    output logic              cfg_rd_req,
    output logic              cfg_wr_en,
    output logic [FR_W-1:0]   cfg_frame,
    output logic [WIDX_W-1:0] cfg_word,
    output logic [DATA_W-1:0] cfg_wr_data,
    input  logic              cfg_rd_ack,
    input  logic [DATA_W-1:0] cfg_rd_data,
    output logic              gm_rd_en,
    output logic [GM_AW-1:0]  gm_addr,
    input  logic [DATA_W-1:0] gm_rd_data,
    input  logic              host_req,
    output logic              host_gnt,
    output logic              busy,
    output logic              pass_done,
    output logic              port_fail,
    output logic [CNT_W-1:0]  fix_count
);
    logic              scrub_want;
    logic              scrub_gnt;
    logic              buf_wr_en;
    logic              buf_sel_gold;
    logic [DATA_W-1:0] buf_rd_data;
    logic [DATA_W-1:0] buf_wr_data;

    scrub_arb i_arb (
        .host_req   (host_req),
        .scrub_want (scrub_want),
        .host_gnt   (host_gnt),
        .scrub_gnt  (scrub_gnt)
    );

    scrub_ctrl #(
        .FRAMES(FRAMES), .WORDS(WORDS), .DATA_W(DATA_W),
        .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)
    ) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .scrub_tick   (scrub_tick),
        .cfg_rd_ack   (cfg_rd_ack),
        .scrub_gnt    (scrub_gnt),
        .gm_rd_data   (gm_rd_data),
        .buf_rd_data  (buf_rd_data),
        .cfg_rd_req   (cfg_rd_req),
        .cfg_wr_en    (cfg_wr_en),
        .scrub_want   (scrub_want),
        .buf_wr_en    (buf_wr_en),
        .buf_sel_gold (buf_sel_gold),
        .frame        (cfg_frame),
        .word         (cfg_word),
        .busy         (busy),
        .pass_done    (pass_done),
        .port_fail    (port_fail),
        .fix_count    (fix_count)
    );

    assign buf_wr_data = buf_sel_gold ? gm_rd_data : cfg_rd_data;

    scrub_frame_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) i_buf (
        .clk     (clk),
        .wr_en   (buf_wr_en),
        .wr_idx  (cfg_word),
        .wr_data (buf_wr_data),
        .rd_idx  (cfg_word),
        .rd_data (buf_rd_data)
    );

    assign gm_rd_en    = scrub_gnt;
    assign gm_addr     = GM_AW'(cfg_frame) * GM_AW'(WORDS) + GM_AW'(cfg_word);
    assign cfg_wr_data = buf_rd_data;

    // R3
    host_excl_chk: assert property (@(posedge clk) disable iff (rst)
        gm_rd_en |-> (host_gnt == 1'b0));
endmodule

// File: tb/test_cfg_scrubber.sv
module test_cfg_scrubber;
    localparam int FRAMES = 8;
    localparam int WORDS  = 4;
    localparam int NW     = FRAMES * WORDS;
    localparam int CMAX   = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scrub_tick = 1'b0;
    logic        cfg_rd_req, cfg_wr_en, gm_rd_en, host_gnt, busy, pass_done, port_fail;
    logic [2:0]  cfg_frame;
    logic [1:0]  cfg_word;
    logic [15:0] cfg_wr_data, cfg_rd_data, gm_rd_data;
    logic        cfg_rd_ack;
    logic [4:0]  gm_addr;
    logic        host_req = 1'b0;
    logic [3:0]  fix_count;

    cfg_scrubber i_cfg_scrubber (
        .clk(clk), .rst(rst), .scrub_tick(scrub_tick),
        .cfg_rd_req(cfg_rd_req), .cfg_wr_en(cfg_wr_en), .cfg_frame(cfg_frame),
        .cfg_word(cfg_word), .cfg_wr_data(cfg_wr_data), .cfg_rd_ack(cfg_rd_ack),
        .cfg_rd_data(cfg_rd_data), .gm_rd_en(gm_rd_en), .gm_addr(gm_addr),
        .gm_rd_data(gm_rd_data), .host_req(host_req), .host_gnt(host_gnt),
        .busy(busy), .pass_done(pass_done), .port_fail(port_fail), .fix_count(fix_count)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [15:0] cmem [NW];
    logic [15:0] gold [NW];
    bit  dead = 0, host_rand = 0, host_force = 0;
    bit  rd_wait = 0, prev_gm = 0;
    int  rd_cd = 0, rd_idx = 0;
    int  wr_cnt = 0, done_cnt = 0, arb_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (host_force) host_req = 1'b1;
        else if (host_rand) host_req = ($urandom % 3) == 0;
        else host_req = 1'b0;
    end

    // memory models, evaluated after the inputs settle
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (gm_rd_en && host_req) arb_bad++;
            if (gm_rd_en && prev_gm) arb_bad++;
            if (host_gnt != host_req) arb_bad++;
            if (pass_done) done_cnt++;
        end
        prev_gm = gm_rd_en;
        if (gm_rd_en) gm_rd_data = gold[gm_addr];
        if (cfg_wr_en) begin
            cmem[int'(cfg_frame) * WORDS + int'(cfg_word)] = cfg_wr_data;
            wr_cnt++;
        end
        cfg_rd_ack = 1'b0;
        if (rd_wait) begin
            if (rd_cd > 1) rd_cd--;
            else begin
                rd_wait = 0;
                if (!dead) begin
                    cfg_rd_ack  = 1'b1;
                    cfg_rd_data = cmem[rd_idx];
                end
            end
        end else if (cfg_rd_req) begin
            rd_wait = 1;
            rd_cd   = 1 + int'($urandom % 3);
            rd_idx  = int'(cfg_frame) * WORDS + int'(cfg_word);
        end
    end

    function automatic int dirty_frames();
        int d = 0;
        for (int f = 0; f < FRAMES; f++) begin
            bit m = 0;
            for (int w = 0; w < WORDS; w++)
                if (cmem[f*WORDS+w] != gold[f*WORDS+w]) m = 1;
            if (m) d++;
        end
        return d;
    endfunction

    function automatic int bad_words();
        int b = 0;
        for (int i = 0; i < NW; i++) if (cmem[i] != gold[i]) b++;
        return b;
    endfunction

    int exp_cnt = 0;

    task automatic pulse_tick();
        @(negedge clk) scrub_tick = 1'b1;
        @(negedge clk) scrub_tick = 1'b0;
    endtask

    task automatic run_pass(input string tag, input bit extra_tick, input bit hold_host);
        int d, lim;
        d = dirty_frames();
        wr_cnt = 0; done_cnt = 0; arb_bad = 0;
        pulse_tick();
        chk(busy == 1'b1, "R1 busy after tick", busy, 1);
        if (extra_tick) begin
            repeat (7) @(negedge clk);
            pulse_tick();
        end
        if (hold_host) begin
            host_force = 1;
            repeat (40) @(negedge clk);
            chk(busy == 1'b1, "R3 pass waits while host holds memory", busy, 1);
            host_force = 0;
        end
        lim = 0;
        while (busy && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
        repeat (12) @(negedge clk);
        #3;
        exp_cnt = (exp_cnt + d > CMAX) ? CMAX : exp_cnt + d;
        $display("pass %s: dirty=%0d", tag, d);
        chk(bad_words() == 0, "R5 config equals golden", bad_words(), 0);
        chk(wr_cnt == d * WORDS, "R4 write count", wr_cnt, d * WORDS);
        chk(fix_count == exp_cnt, "R6 fix_count", fix_count, exp_cnt);
        chk(done_cnt == 1, "R7/R1 pass_done pulses", done_cnt, 1);
        chk(arb_bad == 0, "R3 arbitration", arb_bad, 0);
        chk(port_fail == 1'b0, "R8 no port_fail", port_fail, 0);
    endtask

    task automatic corrupt(input int nfr);
        for (int k = 0; k < nfr; k++) begin
            int f = int'($urandom % FRAMES);
            int w = int'($urandom % WORDS);
            cmem[f*WORDS+w] = cmem[f*WORDS+w] ^ (16'h1 << ($urandom % 16));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) begin
            gold[i] = 16'($urandom);
            cmem[i] = gold[i];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #3;
        // R9
        chk(busy == 0 && pass_done == 0 && port_fail == 0, "R9 reset flags", {busy, pass_done, port_fail}, 0);
        chk(fix_count == 0, "R9 reset fix_count", fix_count, 0);
        chk(cfg_rd_req == 0 && cfg_wr_en == 0 && gm_rd_en == 0, "R9 reset strobes",
            {cfg_rd_req, cfg_wr_en, gm_rd_en}, 0);

        // R4 clean image: no writes; R2 reads every word
        run_pass("clean", 0, 0);
        // R4 boundary: only the last word of the last frame
        cmem[NW-1] = ~cmem[NW-1];
        run_pass("last word", 0, 0);
        // R4 boundary: first word of first frame, with extra tick (R1)
        cmem[0] = cmem[0] ^ 16'h8000;
        run_pass("first word + extra tick", 1, 0);
        // R3 host holding memory for a stretch
        host_rand = 1;
        corrupt(3);
        run_pass("host hold", 0, 1);
        // random passes, counter saturates (R6)
        for (int p = 0; p < 5; p++) begin
            corrupt(2 + int'($urandom % 4));
            run_pass("random", 0, 0);
        end
        // every word bad
        for (int i = 0; i < NW; i++) cmem[i] = ~gold[i];
        run_pass("all bad", 0, 0);
        chk(fix_count == CMAX, "R6 saturation", fix_count, CMAX);

        // R8 timeout
        dead = 1;
        done_cnt = 0;
        corrupt(2);
        pulse_tick();
        begin
            int lim = 0;
            while (busy && lim < 200) begin
                @(negedge clk);
                lim++;
            end
            chk(lim < 200, "R8 pass aborted", lim, 200);
        end
        #3;
        chk(port_fail == 1'b1, "R8 port_fail set", port_fail, 1);
        chk(busy == 1'b0, "R8 busy low", busy, 0);
        chk(done_cnt == 0, "R8 no pass_done", done_cnt, 0);
        chk(bad_words() != 0, "R8 nothing repaired", bad_words(), 1);
        dead = 0;
        repeat (5) @(negedge clk);
        pulse_tick();
        #3;
        chk(port_fail == 1'b0, "R8 port_fail cleared on new pass", port_fail, 0);
        begin
            int lim = 0;
            while (busy && lim < 20000) begin
                @(negedge clk);
                lim++;
            end
        end
        repeat (4) @(negedge clk);
        #3;
        chk(bad_words() == 0, "R5 repaired after recovery", bad_words(), 0);
        host_rand = 0;
        finish_run();
    end
endmodule